// File: doc/BRIEF.md
# Data Address Generation Unit

This block forms the 16-bit data-memory address for each access a processor core requests. A direct access uses a 9-bit page register as the upper part of the address and the 7-bit offset field of the current instruction as the lower part. An indirect access uses one of eight 16-bit pointer registers as the address. A 3-bit select register chooses the pointer. After the access, the block can step the chosen pointer by one or by the value in pointer register 0. All pointer arithmetic is unsigned and wraps modulo 2^16.

Pointer register 0 has two uses. It is the stride for the two index step codes. It is also the reference value for a comparator that tests the currently selected pointer against it. The address is registered and appears one cycle after the request. The page register, the pointer select and every pointer register can be loaded through dedicated write ports.

Top module: `dagu_top`

## Requirements
- R1: Synchronous active-high reset clears `addr_out`, `addr_vld`, the page register, the pointer select and all eight pointer registers to zero.
- R2: When `acc_req`=1 and `acc_ind`=0, `addr_out` becomes {page, `insn_ofs`} at the next clock edge, with the page in bits 15:7, and `addr_vld` is 1 in that cycle.
- R3: When `acc_req`=1 and `acc_ind`=1, `addr_out` becomes the value that the selected pointer held before that access's update.
- R4: On an indirect access, `upd_code` changes the selected pointer after the access: 0 leaves it unchanged, 1 adds one, 2 subtracts one, 3 adds pointer 0, 4 subtracts pointer 0, and 5 to 7 leave it unchanged. Results wrap modulo 65536. Pointer 0 is read as it was before the edge.
- R5: When `ptr_wr`=1, the pointer select takes `ptr_new` at the clock edge. An indirect access in that same cycle still uses, and updates, the old selection.
- R6: `cmp_hit` compares the selected pointer with pointer 0 combinationally and unsigned. `cmp_sel` 0 tests equal, 1 tests less-than, 2 tests greater-than and 3 tests not-equal.
- R7: When `page_wr`=1, the page register takes `page_din` at the clock edge. A direct access in the same cycle uses the old page.
- R8: When `reg_wr`=1, pointer `reg_idx` is loaded with `reg_din`. If an indirect update targets the same pointer in the same cycle, the load wins.
- R9: In a cycle after one with `acc_req`=0, `addr_vld` is 0 and `addr_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Address request this cycle |
| acc_ind | input | 1 | 1 selects indirect mode, 0 selects direct mode |
| insn_ofs | input | 7 | Instruction offset for direct mode |
| upd_code | input | 3 | Post-access pointer update code |
| ptr_wr | input | 1 | Load the pointer select |
| ptr_new | input | 3 | New pointer select value |
| page_wr | input | 1 | Load the page register |
| page_din | input | 9 | New page value |
| reg_wr | input | 1 | Load a pointer register |
| reg_idx | input | 3 | Pointer register to load |
| reg_din | input | 16 | Value to load |
| cmp_sel | input | 2 | Comparison condition |
| addr_out | output | 16 | Registered address |
| addr_vld | output | 1 | Address valid, one cycle after request |
| cmp_hit | output | 1 | Comparison result |

## Verification
The bench runs every update code on every pointer select. It uses values at 0x0000 and 0xFFFF so that the steps wrap. A design without the wrap, or one that reads pointer 0 after the edge, would report a wrong address on the readback access. It also selects pointer 0 and steps it by itself, which only a design that reads pointer 0 before the edge gets right. Other cases check that a select change, a page write and a pointer write landing in the same cycle as an access act in the required order. A design with the wrong priority would issue the new page or select too early, or let the update overwrite the load. The comparator is run in all four conditions against equal, smaller and larger pointers. This catches a signed comparison or swapped operands.

// File: rtl/dagu_pkg.sv
package dagu_pkg;
    localparam int ADDR_W = 16;
    localparam int PAGE_W = 9;
    localparam int OFS_W  = ADDR_W - PAGE_W;
    localparam int N_PTR  = 8;
    localparam int SEL_W  = $clog2(N_PTR);

    typedef enum logic [2:0] {
        UPD_NONE = 3'd0,
        UPD_INC  = 3'd1,
        UPD_DEC  = 3'd2,
        UPD_ADDX = 3'd3,
        UPD_SUBX = 3'd4
    } upd_e;

    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_LT = 2'd1,
        CMP_GT = 2'd2,
        CMP_NE = 2'd3
    } cmp_e;

    typedef struct packed {
        logic              en;
        logic [SEL_W-1:0]  idx;
        logic [ADDR_W-1:0] val;
    } reg_wr_t;

    function automatic logic [ADDR_W-1:0] step_ptr(
        input logic [ADDR_W-1:0] base,
        input logic [2:0]        code,
        input logic [ADDR_W-1:0] stride
    );
        case (code)
            UPD_INC:  return base + 1'b1;
            UPD_DEC:  return base - 1'b1;
            UPD_ADDX: return base + stride;
            UPD_SUBX: return base - stride;
            default:  return base;
        endcase
    endfunction
endpackage

// File: rtl/dagu_regfile.sv
module dagu_regfile
    import dagu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_val,
    input  reg_wr_t           ld,
    input  logic              sel_wr,
    input  logic [SEL_W-1:0]  sel_new,
    output logic [ADDR_W-1:0] cur_val,
    output logic [ADDR_W-1:0] base_val,
    output logic [SEL_W-1:0]  sel_q
);
    logic [ADDR_W-1:0] ptr_q [N_PTR];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_PTR; i++) ptr_q[i] <= '0;
            sel_q <= '0;
        end else begin
            for (int i = 0; i < N_PTR; i++) begin
                if (ld.en && ld.idx == SEL_W'(i))
                    ptr_q[i] <= ld.val;
                else if (upd_en && sel_q == SEL_W'(i))
                    ptr_q[i] <= upd_val;
            end
            if (sel_wr) sel_q <= sel_new;
        end
    end

    assign cur_val  = ptr_q[sel_q];
    assign base_val = ptr_q[0];

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sel_wr |=> $stable(sel_q)); // R5
    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> sel_q == $past(sel_new)); // R5
endmodule

// File: rtl/dagu_arau.sv
module dagu_arau
    import dagu_pkg::*;
(
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] stride,
    input  logic [2:0]        code,
    output logic [ADDR_W-1:0] nxt
);
    always_comb nxt = step_ptr(cur, code, stride);
endmodule

// File: rtl/dagu_cmp.sv
module dagu_cmp
    import dagu_pkg::*;
(
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    input  logic [1:0]        mode,
    output logic              hit
);
    always_comb begin
        case (mode)
            CMP_EQ:  hit = (a == b);
            CMP_LT:  hit = (a <  b);
            CMP_GT:  hit = (a >  b);
            default: hit = (a != b);
        endcase
    end
endmodule

// File: rtl/dagu_top.sv
module dagu_top
    import dagu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_req,
    input  logic              acc_ind,
    input  logic [OFS_W-1:0]  insn_ofs,
    input  logic [2:0]        upd_code,
    input  logic              ptr_wr,
    input  logic [SEL_W-1:0]  ptr_new,
    input  logic              page_wr,
    input  logic [PAGE_W-1:0] page_din,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_idx,
    input  logic [ADDR_W-1:0] reg_din,
    input  logic [1:0]        cmp_sel,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_vld,
    output logic              cmp_hit
);
    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] cur_val, base_val, nxt_val;
    logic [SEL_W-1:0]  sel_q;
    reg_wr_t           ld;

    assign ld = '{en: reg_wr, idx: reg_idx, val: reg_din};

    dagu_regfile u_rf (
        .clk(clk), .rst(rst),
        .upd_en(acc_req & acc_ind), .upd_val(nxt_val),
        .ld(ld), .sel_wr(ptr_wr), .sel_new(ptr_new),
        .cur_val(cur_val), .base_val(base_val), .sel_q(sel_q)
    );

    dagu_arau u_arau (
        .cur(cur_val), .stride(base_val), .code(upd_code), .nxt(nxt_val)
    );

    dagu_cmp u_cmp (
        .a(cur_val), .b(base_val), .mode(cmp_sel), .hit(cmp_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q   <= '0;
            addr_out <= '0;
            addr_vld <= 1'b0;
        end else begin
            addr_vld <= acc_req;
            if (acc_req)
                addr_out <= acc_ind ? cur_val : {page_q, insn_ofs};
            if (page_wr) page_q <= page_din;
        end
    end

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        acc_req |=> addr_vld); // R2
    AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (rst)
        acc_req && !acc_ind |=> addr_out[OFS_W-1:0] == $past(insn_ofs)); // R2
    AST_INDIRECT_ADDR: assert property (@(posedge clk) disable iff (rst)
        acc_req && acc_ind |=> addr_out == $past(cur_val)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !acc_req |=> !addr_vld && $stable(addr_out)); // R9
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        reg_wr && !ptr_wr && acc_req && acc_ind && reg_idx == sel_q |=> cur_val == $past(reg_din)); // R8
endmodule

// File: tb/sim_dagu_top.sv
module sim_dagu_top;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        acc_req = 0, acc_ind = 0, ptr_wr = 0, page_wr = 0, reg_wr = 0;
    logic [6:0]  insn_ofs = 0;
    logic [2:0]  upd_code = 0, ptr_new = 0, reg_idx = 0;
    logic [8:0]  page_din = 0;
    logic [15:0] reg_din = 0;
    logic [1:0]  cmp_sel = 0;
    logic [15:0] addr_out;
    logic        addr_vld, cmp_hit;

    int total = 0, bad = 0;
    logic [15:0] m_ar [8];
    logic [2:0]  m_sel;
    logic [8:0]  m_pg;
    logic [15:0] m_addr;
    logic        m_vld;

    always #(CLK_P/2) clk = ~clk;

    dagu_top u0 (.*);

    function automatic logic [15:0] mstep(logic [15:0] b, logic [2:0] c, logic [15:0] s);
        int r;
        case (c)
            3'd1: r = int'(b) + 1;
            3'd2: r = int'(b) - 1 + 65536;
            3'd3: r = int'(b) + int'(s);
            3'd4: r = int'(b) - int'(s) + 65536;
            default: r = int'(b);
        endcase
        return 16'(r % 65536);
    endfunction

    function automatic logic mcmp(logic [15:0] a, logic [15:0] b, logic [1:0] m);
        case (m)
            2'd0: return a == b;
            2'd1: return a < b;
            2'd2: return a > b;
            default: return a != b;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, model at posedge, check at next negedge
    task automatic cyc(string tag, logic rq, logic ind, logic [6:0] ofs, logic [2:0] uc,
                       logic pw, logic [2:0] pn, logic gw, logic [8:0] gd,
                       logic rw, logic [2:0] ri, logic [15:0] rd, logic [1:0] cm);
        logic [15:0] upd;
        acc_req = rq; acc_ind = ind; insn_ofs = ofs; upd_code = uc;
        ptr_wr = pw; ptr_new = pn; page_wr = gw; page_din = gd;
        reg_wr = rw; reg_idx = ri; reg_din = rd; cmp_sel = cm;
        @(posedge clk);
        m_vld = rq;
        upd = mstep(m_ar[m_sel], uc, m_ar[0]);
        if (rq) m_addr = ind ? m_ar[m_sel] : {m_pg, ofs};
        if (rq && ind) m_ar[m_sel] = upd;
        if (rw) m_ar[ri] = rd;
        if (gw) m_pg = gd;
        if (pw) m_sel = pn;
        @(negedge clk);
        chk({tag, " addr"}, 32'(addr_out), 32'(m_addr));
        chk({tag, " vld"}, 32'(addr_vld), 32'(m_vld));
        chk("R6 cmp", 32'(cmp_hit), 32'(mcmp(m_ar[m_sel], m_ar[0], cm)));
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_ar[i] = 0;
        m_sel = 0; m_pg = 0; m_addr = 0; m_vld = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1 addr", 32'(addr_out), 0);
        chk("R1 vld", 32'(addr_vld), 0);
        chk("R1 cmp", 32'(cmp_hit), 1);
        for (int i = 0; i < 8; i++) begin
            cyc("R1", 0, 0, 0, 0, 1, 3'(i), 0, 0, 0, 0, 0, 0);
            cyc("R1", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        end
        // R2 / R7: direct sweep, page written in the same cycle as the access
        for (int p = 0; p < 3; p++)
            for (int o = 0; o < 128; o++)
                cyc("R7", 1, 0, 7'(o), 0, o == 64, 0, 1'(o == 64),
                    9'(p * 171 + o), 0, 0, 0, 2'(o));
        cyc("R2", 1, 0, 7'h55, 0, 0, 0, 1, 9'h1FF, 0, 0, 0, 0);
        cyc("R2", 1, 0, 7'h2A, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R4 / R3: every update code on every pointer, with wrap values
        for (int s = 0; s < 8; s++)
            for (int c = 0; c < 8; c++)
                for (int v = 0; v < 3; v++) begin
                    logic [15:0] val;
                    val = (v == 0) ? 16'hFFFF : (v == 1) ? 16'h0000 : 16'(s * 4099 + c * 77);
                    cyc("R8", 0, 0, 0, 0, 1, 3'(s), 0, 0, 1, 0, 16'(16'hF000 + c * 9 + v), 0);
                    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'(s), val, 2'(v));
                    cyc("R4", 1, 1, 0, 3'(c), 0, 0, 0, 0, 0, 0, 0, 2'(c));
                    cyc("R3", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'(s));
                end
        // R5: select change in the same cycle as an indirect update
        cyc("R5", 0, 0, 0, 0, 1, 3, 0, 0, 1, 5, 16'h1234, 0);
        cyc("R5", 1, 1, 0, 1, 1, 5, 0, 0, 1, 3, 16'h0100, 0);
        cyc("R5", 1, 1, 0, 2, 1, 3, 0, 0, 0, 0, 0, 3);
        cyc("R5", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R8: load collides with update of the same pointer
        cyc("R8", 1, 1, 0, 3, 0, 0, 0, 0, 1, 3, 16'hBEEF, 2);
        cyc("R8", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R6: comparator against smaller, equal, larger
        for (int k = 0; k < 3; k++)
            for (int m = 0; m < 4; m++) begin
                cyc("R6", 0, 0, 0, 0, 1, 2, 0, 0, 1, 0, 16'h8000, 2'(m));
                cyc("R6", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 16'(16'h7FFF + k), 2'(m));
            end
        // R9: idle cycles hold the address
        for (int i = 0; i < 5; i++)
            cyc("R9", 0, 1'(i), 7'(i), 3'(i), 0, 0, 0, 0, 0, 0, 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule